// File: doc/BRIEF.md
# UTOPIA Level 2 Transmit Port (PHY side)

This block is the physical-layer end of the transmit direction of a 16-bit multi-PHY cell bus. The ATM device shares one address bus, one data bus, an active-low enable, a start-of-cell flag and a parity bit among several PHY ports. It finds out which ports can take a cell by polling their addresses. It then selects one port and streams a 27-word cell into it. The 53-byte cell is padded to 54 bytes by a filler byte that sits between the 5-byte header and the 48-byte payload.

The port compares the polled address with its own configured 5-bit address. When the two match, it drives the shared cell-available line one clock later; at all other times it leaves that line floating. When the port is selected, it accepts words only on cycles where the enable is low. It checks odd parity on every accepted word and removes the filler byte. It writes the 53 remaining bytes into a small circular cell buffer, and a downstream consumer pops that buffer one byte at a time. A cell counts as stored only once its last word has arrived.

The capture state machine has four states. In CAP_IDLE it waits for a start of cell. In CAP_HEAD it takes words 0 to 2, which carry the header and the filler. In CAP_BODY it takes the payload words. In CAP_SKIP it discards a cell that arrived with no free slot. Any accepted word that carries the start flag moves the machine to CAP_HEAD when a slot is free, and to CAP_SKIP when none is. CAP_HEAD moves to CAP_BODY after word 2. CAP_BODY returns to CAP_IDLE after word 26 and commits the cell at that point. In CAP_IDLE and CAP_SKIP, accepted words without the start flag leave the state unchanged.

Top module: `utp2_tx_port`

## Requirements
- R1: The port address is the 5-bit value on `port_id`, and only this address is answered or selected.
- R2: When `tx_addr` equals `port_id` at a rising clock edge, `tx_clav` is driven after that edge, and its value is the buffer room condition of R9 sampled at that edge.
- R3: When `tx_addr` differs from `port_id` at a rising clock edge, `tx_clav` is high impedance after that edge.
- R4: The port becomes selected at an edge where `tx_en_n` is high and `tx_addr` equals `port_id`. It is deselected at an edge where `tx_en_n` is high and the address differs. A word is accepted only at an edge where the port is selected and `tx_en_n` is low, so cycles with `tx_en_n` high pause a cell without losing it.
- R5: An accepted word with `tx_soc` high is word 0 of a cell. Accepted words without `tx_soc` are ignored when no cell capture is in progress.
- R6: Word k carries two cell bytes, `tx_data[15:8]` first and then `tx_data[7:0]`. Words 0 and 1 carry bytes 0 to 3. Word 2 carries byte 4 in its upper half and the filler in its lower half, and the filler is discarded. Words 3 to 26 carry bytes 5 to 52. The 53 bytes are read out in this order.
- R7: An accepted word with `tx_soc` high during a capture drops the partial cell and starts a new cell with that word.
- R8: A word is valid when `tx_data` and `tx_par` together hold an odd number of ones. An accepted invalid word sets `par_err`, which stays high until reset, and the cell is still stored.
- R9: The room condition is true only when the buffer can hold one more complete cell beyond the committed bytes, counting a capture in progress as a full cell.
- R10: A cell whose first word arrives when the committed bytes leave no free cell slot is discarded completely.
- R11: `rd_avail` is high while at least one byte is stored. `rd_byte` shows the oldest byte, and `rd_en` with `rd_avail` high removes that byte. A pop and a cell commit in the same cycle are both applied.
- R12: After reset `tx_clav` is not driven, the buffer is empty and `par_err` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_id | input | 5 | Configured address of this port |
| tx_addr | input | 5 | Poll and select address from the ATM side |
| tx_en_n | input | 1 | Active-low transfer enable |
| tx_soc | input | 1 | Start-of-cell flag, high with word 0 |
| tx_data | input | 16 | Cell word |
| tx_par | input | 1 | Odd parity bit over `tx_data` |
| tx_clav | output | 1 | Cell-available answer, high impedance unless addressed |
| rd_en | input | 1 | Pop one byte from the cell buffer |
| rd_byte | output | 8 | Oldest stored byte |
| rd_avail | output | 1 | Buffer holds at least one byte |
| par_err | output | 1 | Sticky parity error flag |

## Verification
Cell capture and poll answering can fall in the same cycle. The ATM side keeps the port's address on the bus while it streams a cell, so the port answers a poll at every edge during the transfer. The bench samples `tx_clav` in the middle of a cell, once with an empty buffer and once with one cell already stored. It checks that the capture in progress is counted as a whole cell (1, then 0). A second overlap, a byte pop and a cell commit at the same edge, is provoked by draining one cell while the next one streams in. It is judged by reading back both cells byte for byte against values computed in the bench.

// File: rtl/utp2_pkg.sv
package utp2_pkg;

    // Capture states of the transmit cell receiver
    typedef enum logic [1:0] {
        CAP_IDLE,   // waiting for a start-of-cell word
        CAP_HEAD,   // header words, including the filler word
        CAP_BODY,   // payload words
        CAP_SKIP    // discarding a cell that found no free slot
    } cap_state_e;

    // True when data plus parity bit hold an odd number of ones
    function automatic logic odd_ok(input logic [15:0] d, input logic p);
        return ^{d, p};
    endfunction

endpackage

// File: rtl/utp2_tx_select.sv
module utp2_tx_select #(
    parameter int unsigned ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_en_n,
    input  logic              room,
    output logic              accept,
    output logic              clav_oe,
    output logic              clav_val
);

    logic addr_hit;
    logic sel_q;

    assign addr_hit = (bus_addr == own_addr);

    // Selection latches while enable is high; poll answer registered every edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q    <= 1'b0;
            clav_oe  <= 1'b0;
            clav_val <= 1'b0;
        end else begin
            if (bus_en_n) begin
                sel_q <= addr_hit;
            end
            clav_oe  <= addr_hit;
            clav_val <= room;
        end
    end

    assign accept = sel_q & ~bus_en_n;

endmodule

// File: rtl/utp2_tx_capture.sv
module utp2_tx_capture
    import utp2_pkg::*;
#(
    parameter int unsigned CELL_WORDS = 27,
    parameter int unsigned HDR_BYTES  = 5,
    localparam int unsigned CELL_BYTES = 2 * CELL_WORDS - 1,
    localparam int unsigned FILL_WORD  = HDR_BYTES / 2,
    localparam int unsigned OFF_W      = $clog2(CELL_BYTES),
    localparam int unsigned WC_W       = $clog2(CELL_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             soc,
    input  logic [15:0]      data,
    input  logic             par,
    input  logic             slot_free,
    output logic             wr_hi_en,
    output logic             wr_lo_en,
    output logic [OFF_W-1:0] wr_hi_off,
    output logic [OFF_W-1:0] wr_lo_off,
    output logic [7:0]       wr_hi_byte,
    output logic [7:0]       wr_lo_byte,
    output logic             commit,
    output logic             busy,
    output logic             par_err
);

    cap_state_e      state_q, state_d;
    logic [WC_W-1:0] wcnt_q, wcnt_d;
    logic [WC_W-1:0] widx;
    int unsigned     hi_pos;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CAP_IDLE;
            wcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            wcnt_q  <= wcnt_d;
        end
    end

    // Sticky parity error
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            par_err <= 1'b0;
        end else if (accept && !odd_ok(data, par)) begin
            par_err <= 1'b1;
        end
    end

    // Next state and write strobes
    always_comb begin
        state_d  = state_q;
        wcnt_d   = wcnt_q;
        widx     = wcnt_q;
        wr_hi_en = 1'b0;
        wr_lo_en = 1'b0;
        commit   = 1'b0;
        if (accept && soc) begin
            widx = '0;
            if (slot_free) begin
                state_d  = CAP_HEAD;
                wcnt_d   = WC_W'(1);
                wr_hi_en = 1'b1;
                wr_lo_en = 1'b1;
            end else begin
                state_d = CAP_SKIP;
                wcnt_d  = '0;
            end
        end else if (accept) begin
            unique case (state_q)
                CAP_IDLE: begin
                end
                CAP_SKIP: begin
                end
                CAP_HEAD: begin
                    wr_hi_en = 1'b1;
                    wr_lo_en = (wcnt_q != WC_W'(FILL_WORD));
                    wcnt_d   = wcnt_q + WC_W'(1);
                    if (wcnt_q == WC_W'(FILL_WORD)) begin
                        state_d = CAP_BODY;
                    end
                end
                CAP_BODY: begin
                    wr_hi_en = 1'b1;
                    wr_lo_en = 1'b1;
                    if (wcnt_q == WC_W'(CELL_WORDS - 1)) begin
                        commit  = 1'b1;
                        state_d = CAP_IDLE;
                        wcnt_d  = '0;
                    end else begin
                        wcnt_d = wcnt_q + WC_W'(1);
                    end
                end
            endcase
        end
    end

    // Byte positions: words past the filler shift down by one byte
    always_comb begin
        if (32'(widx) <= FILL_WORD) begin
            hi_pos = 32'(widx) * 2;
        end else begin
            hi_pos = 32'(widx) * 2 - 1;
        end
        wr_hi_off  = OFF_W'(hi_pos);
        wr_lo_off  = OFF_W'(hi_pos + 1);
        wr_hi_byte = data[15:8];
        wr_lo_byte = data[7:0];
        busy       = (state_q == CAP_HEAD) || (state_q == CAP_BODY);
    end

endmodule

// File: rtl/utp2_tx_cellbuf.sv
module utp2_tx_cellbuf #(
    parameter int unsigned CAP        = 106,
    parameter int unsigned CELL_BYTES = 53,
    localparam int unsigned PTR_W = $clog2(CAP),
    localparam int unsigned CNT_W = $clog2(CAP + 1),
    localparam int unsigned OFF_W = $clog2(CELL_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hi_en,
    input  logic             wr_lo_en,
    input  logic [OFF_W-1:0] wr_hi_off,
    input  logic [OFF_W-1:0] wr_lo_off,
    input  logic [7:0]       wr_hi_byte,
    input  logic [7:0]       wr_lo_byte,
    input  logic             commit,
    input  logic             rd_en,
    output logic [7:0]       rd_byte,
    output logic             rd_avail,
    output logic [CNT_W-1:0] used
);

    logic [7:0]       mem [CAP];
    logic [PTR_W-1:0] base_q;
    logic [PTR_W-1:0] rd_ptr_q;
    logic             pop;

    function automatic logic [PTR_W-1:0] wrap_add(input logic [PTR_W-1:0] a,
                                                  input logic [PTR_W-1:0] b);
        logic [PTR_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s >= (PTR_W + 1)'(CAP)) begin
            s = s - (PTR_W + 1)'(CAP);
        end
        return s[PTR_W-1:0];
    endfunction

    // Uncommitted bytes land past the committed region
    always_ff @(posedge clk) begin
        if (wr_hi_en) begin
            mem[wrap_add(base_q, PTR_W'(wr_hi_off))] <= wr_hi_byte;
        end
        if (wr_lo_en) begin
            mem[wrap_add(base_q, PTR_W'(wr_lo_off))] <= wr_lo_byte;
        end
    end

    assign pop = rd_en && (used != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q   <= '0;
            rd_ptr_q <= '0;
            used     <= '0;
        end else begin
            if (commit) begin
                base_q <= wrap_add(base_q, PTR_W'(CELL_BYTES));
            end
            if (pop) begin
                rd_ptr_q <= wrap_add(rd_ptr_q, PTR_W'(1));
            end
            used <= used + (commit ? CNT_W'(CELL_BYTES) : '0) - (pop ? CNT_W'(1) : '0);
        end
    end

    assign rd_byte  = mem[rd_ptr_q];
    assign rd_avail = (used != '0);

endmodule

// File: rtl/utp2_tx_port.sv
module utp2_tx_port #(
    parameter int unsigned ADDR_W     = 5,
    parameter int unsigned CELL_WORDS = 27,
    parameter int unsigned HDR_BYTES  = 5,
    parameter int unsigned CELL_SLOTS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] port_id,
    input  logic [ADDR_W-1:0] tx_addr,
    input  logic              tx_en_n,
    input  logic              tx_soc,
    input  logic [15:0]       tx_data,
    input  logic              tx_par,
    output logic              tx_clav,
    input  logic              rd_en,
    output logic [7:0]        rd_byte,
    output logic              rd_avail,
    output logic              par_err
);

    localparam int unsigned CELL_BYTES = 2 * CELL_WORDS - 1;
    localparam int unsigned CAP        = CELL_SLOTS * CELL_BYTES;
    localparam int unsigned OFF_W      = $clog2(CELL_BYTES);
    localparam int unsigned CNT_W      = $clog2(CAP + 1);

    logic             accept;
    logic             clav_oe;
    logic             clav_val;
    logic             room;
    logic             slot_free;
    logic             busy;
    logic             commit;
    logic             wr_hi_en, wr_lo_en;
    logic [OFF_W-1:0] wr_hi_off, wr_lo_off;
    logic [7:0]       wr_hi_byte, wr_lo_byte;
    logic [CNT_W-1:0] buf_used;

    // Free-slot tests; a capture in progress reserves a whole cell
    assign slot_free = (int'(buf_used) + int'(CELL_BYTES) <= int'(CAP));
    assign room      = busy ? (int'(buf_used) + 2 * int'(CELL_BYTES) <= int'(CAP)) : slot_free;

    utp2_tx_select #(
        .ADDR_W (ADDR_W)
    ) i_select (
        .clk      (clk),
        .rst_n    (rst_n),
        .own_addr (port_id),
        .bus_addr (tx_addr),
        .bus_en_n (tx_en_n),
        .room     (room),
        .accept   (accept),
        .clav_oe  (clav_oe),
        .clav_val (clav_val)
    );

    assign tx_clav = clav_oe ? clav_val : 1'bz;

    utp2_tx_capture #(
        .CELL_WORDS (CELL_WORDS),
        .HDR_BYTES  (HDR_BYTES)
    ) i_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .soc        (tx_soc),
        .data       (tx_data),
        .par        (tx_par),
        .slot_free  (slot_free),
        .wr_hi_en   (wr_hi_en),
        .wr_lo_en   (wr_lo_en),
        .wr_hi_off  (wr_hi_off),
        .wr_lo_off  (wr_lo_off),
        .wr_hi_byte (wr_hi_byte),
        .wr_lo_byte (wr_lo_byte),
        .commit     (commit),
        .busy       (busy),
        .par_err    (par_err)
    );

    utp2_tx_cellbuf #(
        .CAP        (CAP),
        .CELL_BYTES (CELL_BYTES)
    ) i_cellbuf (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_hi_en   (wr_hi_en),
        .wr_lo_en   (wr_lo_en),
        .wr_hi_off  (wr_hi_off),
        .wr_lo_off  (wr_lo_off),
        .wr_hi_byte (wr_hi_byte),
        .wr_lo_byte (wr_lo_byte),
        .commit     (commit),
        .rd_en      (rd_en),
        .rd_byte    (rd_byte),
        .rd_avail   (rd_avail),
        .used       (buf_used)
    );

endmodule

// File: rtl/utp2_tx_port_chk.sv
module utp2_tx_port_chk #(
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned CNT_W  = 7,
    parameter int unsigned CAP    = 106
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] tx_addr,
    input logic [ADDR_W-1:0] port_id,
    input logic              clav_oe,
    input logic              clav_val,
    input logic              room,
    input logic              accept,
    input logic [15:0]       tx_data,
    input logic              tx_par,
    input logic              par_err,
    input logic [CNT_W-1:0]  buf_used
);

    logic live;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live <= 1'b0;
        else        live <= 1'b1;
    end

    AST_CLAV_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        live && ($past(tx_addr) != $past(port_id)) |-> !clav_oe); // R3

    AST_CLAV_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        live && ($past(tx_addr) == $past(port_id)) |-> clav_oe); // R2

    AST_CLAV_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        live && ($past(tx_addr) == $past(port_id)) |-> (clav_val == $past(room))); // R9

    AST_PAR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !(^{tx_data, tx_par}) |=> par_err); // R8

    AST_PAR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |=> par_err); // R8

    always @(posedge clk) begin
        if (rst_n) begin
            AST_NO_OVERFLOW: assert (int'(buf_used) <= int'(CAP)); // R10
        end
    end

endmodule

bind utp2_tx_port utp2_tx_port_chk #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .CAP    (CAP)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_addr  (tx_addr),
    .port_id  (port_id),
    .clav_oe  (clav_oe),
    .clav_val (clav_val),
    .room     (room),
    .accept   (accept),
    .tx_data  (tx_data),
    .tx_par   (tx_par),
    .par_err  (par_err),
    .buf_used (buf_used)
);

// File: tb/test_utp2_tx_port.sv
module test_utp2_tx_port;

    localparam int FILLER = 8'hA5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  port_id = 5'd3;
    logic [4:0]  tx_addr = 5'd0;
    logic        tx_en_n = 1'b1;
    logic        tx_soc = 1'b0;
    logic [15:0] tx_data = '0;
    logic        tx_par = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_byte;
    logic        rd_avail;
    logic        par_err;
    wire         clav_net;

    pulldown (clav_net);

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    utp2_tx_port i_utp2_tx_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .port_id  (port_id),
        .tx_addr  (tx_addr),
        .tx_en_n  (tx_en_n),
        .tx_soc   (tx_soc),
        .tx_data  (tx_data),
        .tx_par   (tx_par),
        .tx_clav  (clav_net),
        .rd_en    (rd_en),
        .rd_byte  (rd_byte),
        .rd_avail (rd_avail),
        .par_err  (par_err)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] cell_byte(input int seed, input int b);
        return 8'(seed * 7 + b * 3 + 1);
    endfunction

    function automatic logic [15:0] cell_word(input int seed, input int k);
        if (k < 2)  return {cell_byte(seed, 2 * k), cell_byte(seed, 2 * k + 1)};
        if (k == 2) return {cell_byte(seed, 4), 8'(FILLER)};
        return {cell_byte(seed, 2 * k - 1), cell_byte(seed, 2 * k)};
    endfunction

    // Select port sa, then stream nwords words; optional pause, bad parity, mid-cell poll check
    task automatic send_cell(input int seed, input logic [4:0] sa, input int nwords,
                             input int pause, input int bad, input bit with_soc, input int mid_exp);
        @(negedge clk);
        tx_addr = sa;
        tx_en_n = 1'b1;
        tx_soc  = 1'b0;
        for (int k = 0; k < nwords; k++) begin
            if (pause != 0 && k != 0 && (k % pause) == 0) begin
                @(negedge clk);
                tx_en_n = 1'b1;
                tx_soc  = 1'b0;
                tx_data = 16'hFFFF;
            end
            @(negedge clk);
            if (k == 10 && mid_exp >= 0) chk("R9 mid-cell poll", 32'(clav_net), 32'(mid_exp));
            tx_en_n = 1'b0;
            tx_data = cell_word(seed, k);
            tx_soc  = with_soc && (k == 0);
            tx_par  = ~(^cell_word(seed, k)) ^ (k == bad);
        end
        @(negedge clk);
        tx_en_n = 1'b1;
        tx_soc  = 1'b0;
    endtask

    task automatic drain(input int seed);
        for (int b = 0; b < 53; b++) begin
            @(negedge clk);
            chk("R11 avail", 32'(rd_avail), 32'd1);
            chk("R6 byte order", 32'(rd_byte), 32'(cell_byte(seed, b)));
            rd_en = 1'b1;
        end
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic poll(input logic [4:0] a, input logic exp, input string req);
        @(negedge clk);
        tx_addr = a;
        tx_en_n = 1'b1;
        @(negedge clk);
        chk(req, 32'(clav_net), 32'(exp));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        n_cmp++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        int owns [4] = '{0, 5, 17, 31};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        chk("R12 clav floating", 32'(clav_net), 32'd0);
        chk("R12 empty", 32'(rd_avail), 32'd0);
        chk("R12 par_err", 32'(par_err), 32'd0);

        // R1 R2 R3: every address against several own addresses
        for (int oi = 0; oi < 4; oi++) begin
            port_id = 5'(owns[oi]);
            for (int a = 0; a < 32; a++) begin
                poll(5'(a), (a == owns[oi]), (a == owns[oi]) ? "R2 R1 addressed" : "R3 R1 floating");
            end
        end
        port_id = 5'd17;

        // R6: plain cell
        send_cell(1, 5'd17, 27, 0, -1, 1'b1, 1);
        drain(1);
        chk("R11 empty after drain", 32'(rd_avail), 32'd0);

        // R4: paused cell
        send_cell(2, 5'd17, 27, 3, -1, 1'b1, -1);
        drain(2);

        // R4: cell sent to another port is not taken
        send_cell(3, 5'd9, 27, 0, -1, 1'b1, -1);
        @(negedge clk);
        chk("R4 other port ignored", 32'(rd_avail), 32'd0);

        // R5: words without start flag in idle
        send_cell(4, 5'd17, 27, 0, -1, 1'b0, -1);
        @(negedge clk);
        chk("R5 no soc ignored", 32'(rd_avail), 32'd0);

        // R7: restart on start flag mid-cell
        send_cell(9, 5'd17, 10, 0, -1, 1'b1, -1);
        send_cell(10, 5'd17, 27, 0, -1, 1'b1, -1);
        drain(10);
        chk("R7 partial dropped", 32'(rd_avail), 32'd0);

        // R9 R10: fill, poll, overflow drop
        send_cell(20, 5'd17, 27, 0, -1, 1'b1, 1);
        send_cell(21, 5'd17, 27, 0, -1, 1'b1, 0);
        poll(5'd17, 1'b0, "R9 full poll");
        send_cell(22, 5'd17, 27, 0, -1, 1'b1, -1);
        drain(20);
        drain(21);
        chk("R10 third cell dropped", 32'(rd_avail), 32'd0);
        poll(5'd17, 1'b1, "R9 empty poll");

        // R11: pop and commit overlap
        send_cell(30, 5'd17, 27, 0, -1, 1'b1, -1);
        fork
            send_cell(31, 5'd17, 27, 0, -1, 1'b1, -1);
            drain(30);
        join
        drain(31);
        chk("R11 empty after overlap", 32'(rd_avail), 32'd0);

        // R8: parity
        chk("R8 clean", 32'(par_err), 32'd0);
        send_cell(40, 5'd17, 27, 0, 7, 1'b1, -1);
        @(negedge clk);
        chk("R8 set", 32'(par_err), 32'd1);
        send_cell(41, 5'd17, 27, 0, -1, 1'b1, -1);
        @(negedge clk);
        chk("R8 sticky", 32'(par_err), 32'd1);
        drain(40);
        drain(41);

        // R12: reset again
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 par_err cleared", 32'(par_err), 32'd0);
        chk("R12 buffer cleared", 32'(rd_avail), 32'd0);
        poll(5'd17, 1'b1, "R12 room after reset");

        summary();
        $finish;
    end

endmodule